// File: doc/BRIEF.md
# Bridge Byte-Lane Parity and Poison Forwarding Unit

This unit sits on the data path of a bus bridge, between a wide internal bus and an external bus port. Every address the bridge launches onto the internal bus gets one even-parity bit per byte lane. Internal-bus data heading out of the chip is checked lane by lane, and external data heading into the chip is given fresh internal parity. The same path serves outbound writes and inbound read returns (internal to external), and inbound writes and outbound read returns (external to internal). The parity handling does not depend on which protocol mode the external port is running in.

A corrupted word is never silently repaired. When an internal-to-external word arrives with a bad lane, the unit regenerates parity on the external side, inverts every parity bit and raises the external error flag. Because the error was found on the internal side, it is logged here, and a one-cycle pulse with a lane mask goes to a logging block. When an external-to-internal word arrives with bad parity, or with the external error flag set, the unit inverts every internal parity bit. In that direction the receiver on the internal bus owns the logging, so the detection pulse is informational only.

Each of the three paths (address, internal to external, external to internal) is a valid/ready stream with a single register stage. A word moves on a cycle where valid and ready are both high. The downstream side may hold ready low for any length of time. While it does, the stage keeps its word unchanged, and the upstream ready drops only if a word is held and the downstream is not taking it. The three paths never stall one another.

Top module: `bridge_lane_parity`

## Requirements
- R1: The address path outputs the 36-bit address with 5 even-parity bits. Bit i (i=0..3) makes addr[8i+7:8i] together with that bit XOR to 0, and bit 4 does the same for the partial lane addr[35:32]. The address appears one register stage after acceptance.
- R2: On the internal-to-external path, a word whose 16 parity bits all match sends its 128 data bits unchanged. Its external parity bit i makes data[8i+7:8i] XOR to 0, and the external error flag is 0.
- R3: On the internal-to-external path, a word with at least one mismatching lane sends its data unchanged, with every one of the 16 external parity bits inverted from even parity and the external error flag set to 1.
- R4: The internal-side error pulse is high for exactly the cycle in which a mismatching word first appears at the external output. Its 16-bit mask has bit i set when lane i (data[8i+7:8i] with parity bit i) mismatched. The mask is zero whenever the pulse is low.
- R5: On the external-to-internal path, a word with matching parity and a clear error flag sends its data unchanged with even internal parity per lane.
- R6: On the external-to-internal path, a word with any mismatching lane sends all 16 internal parity bits inverted. The external-side detection pulse and mask behave as in R4 on that path.
- R7: An external-to-internal word with good parity but with its error flag set sends all 16 internal parity bits inverted and raises no detection pulse.
- R8: Each path holds at most one word and passes it on after one register stage. A held word stays unchanged while the output is stalled. Input ready equals "stage empty or output ready", and each path is independent of the other two.
- R9: During reset every output valid, both error pulses and both masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adr_in_valid | input | 1 | Address offered for internal launch |
| adr_in_ready | output | 1 | Address stage can accept |
| adr_in_addr | input | 36 | Address to launch |
| adr_out_valid | output | 1 | Address with parity available |
| adr_out_ready | input | 1 | Internal bus takes the address |
| adr_out_addr | output | 36 | Launched address |
| adr_out_par | output | 5 | Per-lane even parity of the address |
| i2e_in_valid | input | 1 | Internal data word offered |
| i2e_in_ready | output | 1 | Internal-to-external stage can accept |
| i2e_in_data | input | 128 | Internal data |
| i2e_in_par | input | 16 | Received per-lane parity |
| i2e_out_valid | output | 1 | External word available |
| i2e_out_ready | input | 1 | External side takes the word |
| i2e_out_data | output | 128 | External data |
| i2e_out_par | output | 16 | External parity, all inverted when poisoned |
| i2e_out_err | output | 1 | External error flag |
| i2e_perr_pulse | output | 1 | Internal-side parity error, log locally |
| i2e_perr_lanes | output | 16 | Mismatching lanes of that word |
| e2i_in_valid | input | 1 | External data word offered |
| e2i_in_ready | output | 1 | External-to-internal stage can accept |
| e2i_in_data | input | 128 | External data |
| e2i_in_par | input | 16 | External per-lane parity |
| e2i_in_err | input | 1 | External error flag |
| e2i_out_valid | output | 1 | Internal word available |
| e2i_out_ready | input | 1 | Internal bus takes the word |
| e2i_out_data | output | 128 | Internal data |
| e2i_out_par | output | 16 | Internal parity, all inverted when poisoned |
| e2i_perr_pulse | output | 1 | External-side parity error detected |
| e2i_perr_lanes | output | 16 | Mismatching lanes of that word |

## Verification
The unit's only state is the held word and valid bit of each stage, plus the two registered pulses. If the valid bit is lost or duplicated, it shows at the output valid or input ready within the next cycle: a word goes missing, or one is presented twice. A poison decision that is held wrongly appears as parity that is even, or inverted, on the very word that leaves the stage, and a pulse that is late or stuck shows one cycle after acceptance. The bench therefore compares every port on every cycle against a queue model, under random stalls, random lane corruption and external error flags.

// File: rtl/br_par_pkg.sv
`timescale 1ns/1ps
package br_par_pkg;
  localparam int LANE_W = 8;

  function automatic int lane_count(input int width);
    return (width + LANE_W - 1) / LANE_W;
  endfunction
endpackage

// File: rtl/br_lane_parity.sv
`timescale 1ns/1ps
// Even parity per byte lane; the top lane may be partial.
module br_lane_parity #(
  parameter int W = 128
) (
  input  logic [W-1:0]                         din,
  output logic [br_par_pkg::lane_count(W)-1:0] par
);
  localparam int NL = br_par_pkg::lane_count(W);
  localparam int LW = br_par_pkg::LANE_W;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int LO = i * LW;
    localparam int HI = ((LO + LW) > W) ? (W - 1) : (LO + LW - 1);
    assign par[i] = ^din[HI:LO];
  end
endmodule

// File: rtl/br_pipe_stage.sv
`timescale 1ns/1ps
// One-entry valid/ready register stage.
module br_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) d_q <= in_data;
  end

  // R8: a stalled word is held unchanged
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8: stage empties or stays full only as the handshake allows
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: rtl/bridge_lane_parity.sv
`timescale 1ns/1ps
module bridge_lane_parity #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      adr_in_valid,
  output logic                                      adr_in_ready,
  input  logic [ADDR_W-1:0]                         adr_in_addr,
  output logic                                      adr_out_valid,
  input  logic                                      adr_out_ready,
  output logic [ADDR_W-1:0]                         adr_out_addr,
  output logic [br_par_pkg::lane_count(ADDR_W)-1:0] adr_out_par,
  input  logic                                      i2e_in_valid,
  output logic                                      i2e_in_ready,
  input  logic [DATA_W-1:0]                         i2e_in_data,
  input  logic [br_par_pkg::lane_count(DATA_W)-1:0] i2e_in_par,
  output logic                                      i2e_out_valid,
  input  logic                                      i2e_out_ready,
  output logic [DATA_W-1:0]                         i2e_out_data,
  output logic [br_par_pkg::lane_count(DATA_W)-1:0] i2e_out_par,
  output logic                                      i2e_out_err,
  output logic                                      i2e_perr_pulse,
  output logic [br_par_pkg::lane_count(DATA_W)-1:0] i2e_perr_lanes,
  input  logic                                      e2i_in_valid,
  output logic                                      e2i_in_ready,
  input  logic [DATA_W-1:0]                         e2i_in_data,
  input  logic [br_par_pkg::lane_count(DATA_W)-1:0] e2i_in_par,
  input  logic                                      e2i_in_err,
  output logic                                      e2i_out_valid,
  input  logic                                      e2i_out_ready,
  output logic [DATA_W-1:0]                         e2i_out_data,
  output logic [br_par_pkg::lane_count(DATA_W)-1:0] e2i_out_par,
  output logic                                      e2i_perr_pulse,
  output logic [br_par_pkg::lane_count(DATA_W)-1:0] e2i_perr_lanes
);
  localparam int AL  = br_par_pkg::lane_count(ADDR_W);
  localparam int DL  = br_par_pkg::lane_count(DATA_W);
  localparam int APW = ADDR_W + AL;
  localparam int IPW = DATA_W + DL + 1;
  localparam int EPW = DATA_W + DL;

  // ---------------- address launch path ----------------
  logic [AL-1:0]  adr_gen;
  logic [APW-1:0] adr_pay;

  br_lane_parity #(.W(ADDR_W)) u_adr_gen (.din(adr_in_addr), .par(adr_gen));

  br_pipe_stage #(.W(APW)) u_adr_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(adr_in_valid), .in_ready(adr_in_ready), .in_data({adr_in_addr, adr_gen}),
    .out_valid(adr_out_valid), .out_ready(adr_out_ready), .out_data(adr_pay)
  );
  assign adr_out_addr = adr_pay[APW-1 -: ADDR_W];
  assign adr_out_par  = adr_pay[AL-1:0];

  // ---------------- internal to external path ----------------
  logic [DL-1:0]  i2e_gen, i2e_mm;
  logic           i2e_bad, i2e_fire;
  logic [IPW-1:0] i2e_pay;

  br_lane_parity #(.W(DATA_W)) u_i2e_gen (.din(i2e_in_data), .par(i2e_gen));

  assign i2e_mm   = i2e_gen ^ i2e_in_par;
  assign i2e_bad  = |i2e_mm;
  assign i2e_fire = i2e_in_valid && i2e_in_ready;

  br_pipe_stage #(.W(IPW)) u_i2e_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(i2e_in_valid), .in_ready(i2e_in_ready),
    .in_data({i2e_in_data, i2e_gen ^ {DL{i2e_bad}}, i2e_bad}),
    .out_valid(i2e_out_valid), .out_ready(i2e_out_ready), .out_data(i2e_pay)
  );
  assign i2e_out_data = i2e_pay[IPW-1 -: DATA_W];
  assign i2e_out_par  = i2e_pay[DL:1];
  assign i2e_out_err  = i2e_pay[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i2e_perr_pulse <= 1'b0;
      i2e_perr_lanes <= '0;
    end else begin
      i2e_perr_pulse <= i2e_fire && i2e_bad;
      i2e_perr_lanes <= i2e_fire ? i2e_mm : '0;
    end
  end

  // R4: the local-log pulse accompanies its word and carries a mask
  p_pulse_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i2e_perr_pulse |-> i2e_out_valid && i2e_out_err);
  p_pulse_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i2e_perr_pulse == (i2e_perr_lanes != '0));
  // R3: poison flag agrees with lane-0 parity seen at the external port
  p_poison_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    i2e_out_valid |-> i2e_out_err == (^{i2e_out_data[7:0], i2e_out_par[0]}));

  // ---------------- external to internal path ----------------
  logic [DL-1:0]  e2i_gen, e2i_mm;
  logic           e2i_bad, e2i_fire;
  logic [EPW-1:0] e2i_pay;

  br_lane_parity #(.W(DATA_W)) u_e2i_gen (.din(e2i_in_data), .par(e2i_gen));

  assign e2i_mm   = e2i_gen ^ e2i_in_par;
  assign e2i_bad  = (|e2i_mm) || e2i_in_err;
  assign e2i_fire = e2i_in_valid && e2i_in_ready;

  br_pipe_stage #(.W(EPW)) u_e2i_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(e2i_in_valid), .in_ready(e2i_in_ready),
    .in_data({e2i_in_data, e2i_gen ^ {DL{e2i_bad}}}),
    .out_valid(e2i_out_valid), .out_ready(e2i_out_ready), .out_data(e2i_pay)
  );
  assign e2i_out_data = e2i_pay[EPW-1 -: DATA_W];
  assign e2i_out_par  = e2i_pay[DL-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e2i_perr_pulse <= 1'b0;
      e2i_perr_lanes <= '0;
    end else begin
      e2i_perr_pulse <= e2i_fire && (|e2i_mm);
      e2i_perr_lanes <= e2i_fire ? e2i_mm : '0;
    end
  end

  // R6: detection pulse only alongside a poisoned internal word
  p_e2i_pulse_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    e2i_perr_pulse |-> e2i_out_valid && ^{e2i_out_data[7:0], e2i_out_par[0]});
  p_e2i_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    e2i_perr_pulse == (e2i_perr_lanes != '0));
endmodule

// File: tb/bridge_lane_parity_bench.sv
`timescale 1ns/1ps
module bridge_lane_parity_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         adr_in_valid = 0, adr_in_ready, adr_out_valid, adr_out_ready = 0;
  logic [35:0]  adr_in_addr = '0, adr_out_addr;
  logic [4:0]   adr_out_par;
  logic         i2e_in_valid = 0, i2e_in_ready, i2e_out_valid, i2e_out_ready = 0, i2e_out_err;
  logic [127:0] i2e_in_data = '0, i2e_out_data;
  logic [15:0]  i2e_in_par = '0, i2e_out_par, i2e_perr_lanes;
  logic         i2e_perr_pulse;
  logic         e2i_in_valid = 0, e2i_in_ready, e2i_out_valid, e2i_out_ready = 0, e2i_in_err = 0;
  logic [127:0] e2i_in_data = '0, e2i_out_data;
  logic [15:0]  e2i_in_par = '0, e2i_out_par, e2i_perr_lanes;
  logic         e2i_perr_pulse;

  bridge_lane_parity u_bridge_lane_parity (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // queued expectations: payload plus the requirement tag of that word
  logic [40:0]  qa[$];
  logic [144:0] qi[$];
  logic [143:0] qe[$];
  string        qi_tag[$];
  string        qe_tag[$];
  logic         xp_i = 0, xp_e = 0;
  logic [15:0]  xm_i = '0, xm_e = '0;

  function automatic logic [15:0] gp128(input logic [127:0] d);
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [4:0] gp36(input logic [35:0] a);
    logic [4:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^a[i*8 +: 8];
    p[4] = ^a[35:32];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(adr_out_valid == (qa.size() > 0), "R8 adr valid", 256'(adr_out_valid), 256'(qa.size() > 0));
    if (adr_out_valid && qa.size() > 0)
      chk({adr_out_addr, adr_out_par} == qa[0], "R1 address parity",
          256'({adr_out_addr, adr_out_par}), 256'(qa[0]));
    chk(i2e_out_valid == (qi.size() > 0), "R8 i2e valid", 256'(i2e_out_valid), 256'(qi.size() > 0));
    if (i2e_out_valid && qi.size() > 0)
      chk({i2e_out_data, i2e_out_par, i2e_out_err} == qi[0], qi_tag[0],
          256'({i2e_out_data, i2e_out_par, i2e_out_err}), 256'(qi[0]));
    chk({i2e_perr_pulse, i2e_perr_lanes} == {xp_i, xm_i}, "R4 local pulse",
        256'({i2e_perr_pulse, i2e_perr_lanes}), 256'({xp_i, xm_i}));
    chk(e2i_out_valid == (qe.size() > 0), "R8 e2i valid", 256'(e2i_out_valid), 256'(qe.size() > 0));
    if (e2i_out_valid && qe.size() > 0)
      chk({e2i_out_data, e2i_out_par} == qe[0], qe_tag[0],
          256'({e2i_out_data, e2i_out_par}), 256'(qe[0]));
    chk({e2i_perr_pulse, e2i_perr_lanes} == {xp_e, xm_e}, "R6 detect pulse",
        256'({e2i_perr_pulse, e2i_perr_lanes}), 256'({xp_e, xm_e}));
  endtask

  function automatic logic [15:0] corrupt(input int rate);
    if (rate > 0 && ($urandom % 100) < rate) begin
      if ($urandom % 2) return 16'(1) << ($urandom % 16);
      return 16'($urandom) | 16'h0001;
    end
    return '0;
  endfunction

  task automatic cycle(input int vrate, input int rrate, input int erate, input int frate,
                       input bit use_dir, input logic [35:0] dir_addr);
    logic [127:0] d;
    logic [15:0]  mm, gp;
    logic         bad;
    @(negedge clk);
    check_outputs();
    adr_in_valid  = ($urandom % 100) < vrate;
    adr_in_addr   = use_dir ? dir_addr : {4'($urandom), 32'($urandom)};
    adr_out_ready = ($urandom % 100) < rrate;
    i2e_in_valid  = ($urandom % 100) < vrate;
    i2e_in_data   = {$urandom, $urandom, $urandom, $urandom};
    i2e_in_par    = gp128(i2e_in_data) ^ corrupt(erate);
    i2e_out_ready = ($urandom % 100) < rrate;
    e2i_in_valid  = ($urandom % 100) < vrate;
    e2i_in_data   = {$urandom, $urandom, $urandom, $urandom};
    e2i_in_par    = gp128(e2i_in_data) ^ corrupt(erate);
    e2i_in_err    = ($urandom % 100) < frate;
    e2i_out_ready = ($urandom % 100) < rrate;
    #1;
    // R8: ready reflects an empty stage or a draining output
    chk(adr_in_ready == (qa.size() == 0 || adr_out_ready), "R8 adr ready",
        256'(adr_in_ready), 256'(qa.size() == 0 || adr_out_ready));
    chk(i2e_in_ready == (qi.size() == 0 || i2e_out_ready), "R8 i2e ready",
        256'(i2e_in_ready), 256'(qi.size() == 0 || i2e_out_ready));
    chk(e2i_in_ready == (qe.size() == 0 || e2i_out_ready), "R8 e2i ready",
        256'(e2i_in_ready), 256'(qe.size() == 0 || e2i_out_ready));
    if (adr_out_valid && adr_out_ready && qa.size() > 0) void'(qa.pop_front());
    if (i2e_out_valid && i2e_out_ready && qi.size() > 0) begin void'(qi.pop_front()); void'(qi_tag.pop_front()); end
    if (e2i_out_valid && e2i_out_ready && qe.size() > 0) begin void'(qe.pop_front()); void'(qe_tag.pop_front()); end
    if (adr_in_valid && adr_in_ready) qa.push_back({adr_in_addr, gp36(adr_in_addr)});
    xp_i = 0; xm_i = '0; xp_e = 0; xm_e = '0;
    if (i2e_in_valid && i2e_in_ready) begin
      d = i2e_in_data; gp = gp128(d); mm = gp ^ i2e_in_par; bad = |mm;
      qi.push_back({d, gp ^ {16{bad}}, bad});
      qi_tag.push_back(bad ? "R3 poisoned external word" : "R2 clean external word");
      xp_i = bad; xm_i = mm;
    end
    if (e2i_in_valid && e2i_in_ready) begin
      d = e2i_in_data; gp = gp128(d); mm = gp ^ e2i_in_par; bad = (|mm) || e2i_in_err;
      qe.push_back({d, gp ^ {16{bad}}});
      qe_tag.push_back((|mm) ? "R6 poisoned internal word" :
                       e2i_in_err ? "R7 flag-poisoned internal word" : "R5 clean internal word");
      xp_e = |mm; xm_e = mm;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] dir [4] = '{36'hF_0000_0000, 36'h1_0000_0001, 36'h0_8000_00FF, 36'h7_0301_0000};
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk({adr_out_valid, i2e_out_valid, e2i_out_valid} == 3'b000, "R9 reset valids",
          256'({adr_out_valid, i2e_out_valid, e2i_out_valid}), 256'(0));
      chk({i2e_perr_pulse, e2i_perr_pulse, i2e_perr_lanes, e2i_perr_lanes} == '0, "R9 reset pulses",
          256'({i2e_perr_pulse, e2i_perr_pulse, i2e_perr_lanes, e2i_perr_lanes}), 256'(0));
    end
    rst_n = 1'b1;
    // directed address corners (partial top lane), no stalls
    for (int k = 0; k < 4; k++) cycle(100, 100, 0, 0, 1, dir[k]);
    // clean traffic with random stalls
    for (int k = 0; k < 800; k++) cycle(70, 60, 0, 0, 0, '0);
    // lane corruption on both data paths
    for (int k = 0; k < 1000; k++) cycle(80, 50, 40, 0, 0, '0);
    // external error flag with otherwise good parity
    for (int k = 0; k < 600; k++) cycle(80, 70, 0, 40, 0, '0);
    // heavy back-pressure, mixed errors
    for (int k = 0; k < 800; k++) cycle(90, 20, 25, 20, 0, '0);
    // drain
    for (int k = 0; k < 10; k++) cycle(0, 100, 0, 0, 0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule